// File: doc/BRIEF.md
# Subframe Slot Transceiver for an 8 kHz TDM Highway

This block attaches one line-interface device to a shared four-wire time-division highway. A frame lasts 125 µs and is marked by an 8 kHz frame-sync pulse. The block counts bit clocks through each frame and picks out one of eight fixed subframes. Inside that subframe it drives four transmit bytes onto the data-out line and shifts in the four bytes arriving on the data-in line. The four bytes are two voice bytes, a monitor byte and a signaling/control byte. Outside its own subframe it releases the data-out line.

Strap pins fix the subframe number and the bit-clock rate. The block latches them during reset and does not change them afterwards, so no register setup is needed. The clock runs at one clock per bit cell (the 2.048 MHz rate) or two clocks per bit cell (the 4.096 MHz rate). On the local side the block has parallel byte ports. The transmit bytes are taken once per frame. The received bytes come out with a one-cycle strobe.

The signaling/control byte is split into a six-bit command/indicate field and a two-bit handshake field. If a sync pulse arrives at the wrong point in the count, the block realigns to that pulse and reports the slip through a sticky flag.

Top module: `tdm_slot_xcvr`

## Requirements
- R1: While `rst` is high, the block captures `strap_sel` (subframe number, 0 to 7) and `strap_2x` (1 = two clocks per bit cell). After reset is released, changes on these pins have no effect.
- R2: The cycle after the edge at which `fsync` is first sampled high (a rising edge of `fsync`) is clock 0 of a frame. A frame is 256 clocks at one clock per bit, or 512 clocks at two clocks per bit.
- R3: Frame bit cell k spans clock k (1x) or clocks 2k and 2k+1 (2x). Subframe n occupies bit cells 32n to 32n+31. Once locked, `tx_oe` is high in exactly the clocks of the strapped subframe and low in all other clocks.
- R4: While `tx_oe` is high, `tx_dout` sends a 32-bit word MSB first. The word is built, from MSB to LSB, from B1, B2, monitor, command/indicate[5:0] and handshake[1:0]. Inside the control byte, command/indicate occupies bits 7:2 and handshake occupies bits 1:0. While `tx_oe` is low, `tx_dout` is 0.
- R5: The transmit ports are captured at the edge that starts a frame. A change to them during a frame affects only the next frame.
- R6: In the strapped subframe, `rx_din` is sampled on the falling clock edge. In 2x mode only the second clock of each bit cell is sampled. Bits are assembled MSB first in the same field layout as R4. The assembled word appears on the `rx_*` ports with `rx_valid` high for one cycle, in the cycle after the subframe's last clock.
- R7: A rising edge of `fsync` at any count other than the frame's last clock, once locked, restarts the frame at clock 0. That new frame gives no `rx_valid` strobe, and `frame_err` rises and stays high until reset.
- R8: After reset and before the first `fsync` rising edge, `tx_oe` and `rx_valid` stay low.
- R9: If no pulse arrives, the count wraps from the last clock to clock 0 by itself. The free-running frame works normally and sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| strap_sel | input | 3 | Subframe number strap |
| strap_2x | input | 1 | Clock-rate strap: 1 = two clocks per bit cell |
| fsync | input | 1 | 8 kHz frame-sync pulse |
| rx_din | input | 1 | Highway receive data |
| tx_b1 | input | 8 | First voice byte to send |
| tx_b2 | input | 8 | Second voice byte to send |
| tx_mon | input | 8 | Monitor byte to send |
| tx_ci | input | 6 | Command/indicate bits to send |
| tx_hs | input | 2 | Handshake bits to send |
| tx_dout | output | 1 | Highway transmit data |
| tx_oe | output | 1 | Output enable for `tx_dout` (low = released) |
| rx_b1 | output | 8 | Received first voice byte |
| rx_b2 | output | 8 | Received second voice byte |
| rx_mon | output | 8 | Received monitor byte |
| rx_ci | output | 6 | Received command/indicate bits |
| rx_hs | output | 2 | Received handshake bits |
| rx_valid | output | 1 | One-cycle strobe: received word is ready |
| frame_err | output | 1 | Sticky flag for a misplaced sync pulse |

## Verification
Some checks are made in every cycle by assertions:
- the straps stay frozen after reset;
- a sync edge always restarts the count at zero, and an unsynced last clock wraps to zero;
- the transmit word holds between frame starts;
- the receive strobe is a single cycle and always directly follows a driven subframe clock;
- the error flag never falls.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the exact position of the slot window for different straps and rates;
- the bit order on the line;
- which clock of a 2x cell is sampled;
- strobe suppression after an early or late pulse;
- free-running across a missing pulse.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    localparam int SLOTS      = 8;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int CNT_W      = $clog2(2 * FRAME_BITS);

    // Line word, first field goes out first (MSB first).
    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] mon;
        logic [5:0] ci;
        logic [1:0] hs;
    } slot_word_t;

    // Where the current clock sits inside the frame.
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic              sample;
    } cell_pos_t;

    function automatic cell_pos_t decode_pos(input logic [CNT_W-1:0] c, input logic dbl);
        cell_pos_t r;
        logic [SLOT_W+BIT_W-1:0] b;
        b        = dbl ? c[CNT_W-1:1] : c[CNT_W-2:0];
        r.slot   = b[BIT_W +: SLOT_W];
        r.bitn   = b[BIT_W-1:0];
        r.sample = !dbl || c[0];
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] last_clk(input logic dbl);
        return dbl ? CNT_W'(2 * FRAME_BITS - 1) : CNT_W'(FRAME_BITS - 1);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dbl,
    input  logic             fsync,
    output logic [CNT_W-1:0] cnt,
    output logic             locked,
    output logic             bad_frame,
    output logic             frame_err,
    output logic             frame_start
);

    logic fs_q;
    logic fs_rise;
    logic at_last;

    assign fs_rise     = fsync & ~fs_q;
    assign at_last     = (cnt == last_clk(dbl));
    assign frame_start = fs_rise | at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            fs_q      <= 1'b0;
            locked    <= 1'b0;
            bad_frame <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            fs_q <= fsync;
            if (fs_rise) begin
                cnt    <= '0;
                locked <= 1'b1;
                if (locked && !at_last) begin
                    bad_frame <= 1'b1;
                    frame_err <= 1'b1;
                end else begin
                    bad_frame <= 1'b0;
                end
            end else if (at_last) begin
                cnt       <= '0;
                bad_frame <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: a sync edge always restarts the count
    a_r2_resync_zero: assert property (@(posedge clk) disable iff (rst)
        fs_rise |=> (cnt == '0));

    // R9: free-running wrap without a pulse
    a_r9_free_wrap: assert property (@(posedge clk) disable iff (rst)
        (!fs_rise && at_last) |=> (cnt == '0));

    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  slot_word_t        word_in,
    input  logic              locked,
    input  cell_pos_t         pos,
    input  logic [SLOT_W-1:0] sel,
    output logic              dout,
    output logic              oe
);

    slot_word_t       word_q;
    logic [BIT_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    // MSB first: bit cell b of the slot carries word bit (SLOT_BITS-1-b)
    assign idx  = ~pos.bitn;
    assign oe   = locked && (pos.slot == sel);
    assign dout = oe & word_q[idx];

    // R5: the transmit word only changes at a frame start
    a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              locked,
    input  logic              bad_frame,
    input  cell_pos_t         pos,
    input  logic [SLOT_W-1:0] sel,
    output slot_word_t        word_out,
    output logic              valid
);

    logic                 din_s;
    logic [SLOT_BITS-1:0] sh;
    logic                 take;

    // Falling-edge capture of the line
    always_ff @(negedge clk) begin
        din_s <= din;
    end

    assign take = locked && (pos.slot == sel) && pos.sample;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            word_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                sh <= {sh[SLOT_BITS-2:0], din_s};
                if (pos.bitn == '1) begin
                    word_out <= {sh[SLOT_BITS-2:0], din_s};
                    valid    <= !bad_frame;
                end
            end
        end
    end

    // R6: strobe lasts exactly one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/tdm_slot_xcvr.sv
module tdm_slot_xcvr
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] strap_sel,
    input  logic              strap_2x,
    input  logic              fsync,
    input  logic              rx_din,
    input  logic [7:0]        tx_b1,
    input  logic [7:0]        tx_b2,
    input  logic [7:0]        tx_mon,
    input  logic [5:0]        tx_ci,
    input  logic [1:0]        tx_hs,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic [7:0]        rx_b1,
    output logic [7:0]        rx_b2,
    output logic [7:0]        rx_mon,
    output logic [5:0]        rx_ci,
    output logic [1:0]        rx_hs,
    output logic              rx_valid,
    output logic              frame_err
);

    logic [SLOT_W-1:0] sel_q;
    logic              dbl_q;
    logic [CNT_W-1:0]  cnt;
    logic              locked;
    logic              bad_frame;
    logic              frame_start;
    cell_pos_t         pos;
    slot_word_t        tx_word;
    slot_word_t        rx_word;

    // Straps are transparent during reset, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= strap_sel;
            dbl_q <= strap_2x;
        end
    end

    assign pos     = decode_pos(cnt, dbl_q);
    assign tx_word = {tx_b1, tx_b2, tx_mon, tx_ci, tx_hs};
    assign {rx_b1, rx_b2, rx_mon, rx_ci, rx_hs} = rx_word;

    tdm_frame_timer i_timer (
        .clk         (clk),
        .rst         (rst),
        .dbl         (dbl_q),
        .fsync       (fsync),
        .cnt         (cnt),
        .locked      (locked),
        .bad_frame   (bad_frame),
        .frame_err   (frame_err),
        .frame_start (frame_start)
    );

    tdm_slot_tx i_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_start),
        .word_in (tx_word),
        .locked  (locked),
        .pos     (pos),
        .sel     (sel_q),
        .dout    (tx_dout),
        .oe      (tx_oe)
    );

    tdm_slot_rx i_rx (
        .clk       (clk),
        .rst       (rst),
        .din       (rx_din),
        .locked    (locked),
        .bad_frame (bad_frame),
        .pos       (pos),
        .sel       (sel_q),
        .word_out  (rx_word),
        .valid     (rx_valid)
    );

    // R1: straps frozen once reset is released
    a_r1_straps_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(sel_q) && $stable(dbl_q)));

    // R6: strobe follows a clock of the owned subframe
    a_r6_strobe_after_slot: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(tx_oe));

endmodule

// File: tb/test_tdm_slot_xcvr.sv
module test_tdm_slot_xcvr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap_sel = 3'd0;
    logic       strap_2x = 1'b0;
    logic       fsync = 1'b0;
    logic       rx_din = 1'b0;
    logic [7:0] tx_b1 = 8'h0, tx_b2 = 8'h0, tx_mon = 8'h0;
    logic [5:0] tx_ci = 6'h0;
    logic [1:0] tx_hs = 2'h0;
    logic       tx_dout, tx_oe, rx_valid, frame_err;
    logic [7:0] rx_b1, rx_b2, rx_mon;
    logic [5:0] rx_ci;
    logic [1:0] rx_hs;

    always #5 clk = ~clk;

    tdm_slot_xcvr i_tdm_slot_xcvr (
        .clk(clk), .rst(rst), .strap_sel(strap_sel), .strap_2x(strap_2x),
        .fsync(fsync), .rx_din(rx_din),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_ci(tx_ci), .tx_hs(tx_hs),
        .tx_dout(tx_dout), .tx_oe(tx_oe),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_ci(rx_ci), .rx_hs(rx_hs),
        .rx_valid(rx_valid), .frame_err(frame_err)
    );

    int    checks = 0;
    int    failures = 0;
    string tag = "reset";
    bit    done = 0;

    // Behavioural reference state
    int          m_pos, m_sel;
    bit          m_locked, m_bad, m_ferr, m_valid, m_dbl, m_fsq;
    logic [31:0] m_txw, m_acc, m_rxout;
    logic [31:0] rx_word = 32'h0;

    function automatic int frame_clks();
        return m_dbl ? 512 : 256;
    endfunction

    function automatic int cell_of(int p);
        return m_dbl ? p / 2 : p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    task automatic step();
        bit   rise;
        int   p;
        int   c;
        logic exp_oe;
        @(posedge clk);
        #1;
        if (rst) begin
            m_pos = 0; m_fsq = 0; m_locked = 0; m_bad = 0; m_ferr = 0;
            m_valid = 0; m_acc = 0; m_rxout = 0; m_txw = 0;
            m_sel = int'(strap_sel); m_dbl = strap_2x;
        end else begin
            p = m_pos;
            c = cell_of(p);
            rise = fsync && !m_fsq;
            m_valid = 0;
            if (m_locked && (c / 32) == m_sel && (!m_dbl || (p % 2) == 1)) begin
                m_acc = {m_acc[30:0], rx_din};
                if (c % 32 == 31) begin
                    m_rxout = m_acc;
                    m_valid = !m_bad;
                end
            end
            if (rise || p == frame_clks() - 1)
                m_txw = {tx_b1, tx_b2, tx_mon, tx_ci, tx_hs};
            if (rise) begin
                if (m_locked && p != frame_clks() - 1) begin
                    m_bad = 1; m_ferr = 1;
                end else begin
                    m_bad = 0;
                end
                m_pos = 0;
                m_locked = 1;
            end else if (p == frame_clks() - 1) begin
                m_pos = 0;
                m_bad = 0;
            end else begin
                m_pos++;
            end
            m_fsq = fsync;
        end
        c = cell_of(m_pos);
        exp_oe = m_locked && (c / 32) == m_sel;
        check("R3 tx_oe window", {31'b0, tx_oe}, {31'b0, exp_oe});
        check("R4 tx_dout bit", {31'b0, tx_dout}, exp_oe ? {31'b0, m_txw[31 - (c % 32)]} : 32'h0);
        check("R6 rx_valid", {31'b0, rx_valid}, {31'b0, m_valid});
        if (m_valid)
            check("R6 rx word", {rx_b1, rx_b2, rx_mon, rx_ci, rx_hs}, m_rxout);
        check("R7 frame_err", {31'b0, frame_err}, {31'b0, m_ferr});
        if (m_locked && (c / 32) == m_sel)
            rx_din = rx_word[31 - (c % 32)];
        else
            rx_din = 1'($urandom);
    endtask

    task automatic new_tx();
        {tx_b1, tx_b2, tx_mon, tx_ci, tx_hs} = $urandom;
    endtask

    // One sync pulse, then len-1 clocks without one
    task automatic run_frames(int n, int len);
        for (int f = 0; f < n; f++) begin
            fsync = 1'b1;
            new_tx();
            rx_word = $urandom;
            step();
            fsync = 1'b0;
            for (int i = 1; i < len; i++) begin
                if (i == len / 3) new_tx();   // R5: mid-frame change
                step();
            end
        end
    endtask

    task automatic do_reset(int sel, bit dbl);
        tag = "reset";
        rst = 1'b1;
        strap_sel = 3'(sel);
        strap_2x = dbl;
        repeat (3) step();
        rst = 1'b0;
        strap_sel = ~strap_sel;   // R1: must be ignored
        strap_2x = ~dbl;
        step();
        check("R8 oe low after reset", {31'b0, tx_oe}, 32'h0);
        check("R8 no strobe after reset", {31'b0, rx_valid}, 32'h0);
        check("R7 flag clear after reset", {31'b0, frame_err}, 32'h0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog [%s] actual=running expected=finished", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(5, 1'b0);
        tag = "R8 idle before sync";
        repeat (300) step();
        tag = "R1 R2 R4 R5 1x frames slot 5";
        run_frames(3, 256);
        tag = "R9 missing pulse";
        run_frames(1, 512);
        run_frames(2, 256);
        tag = "R7 early pulse 1x";
        run_frames(1, 100);
        run_frames(2, 256);

        do_reset(0, 1'b1);
        tag = "R8 idle 2x";
        repeat (50) step();
        tag = "R2 R3 R6 2x frames slot 0";
        run_frames(3, 512);
        tag = "R7 late pulse 2x";
        run_frames(1, 600);
        run_frames(2, 512);

        do_reset(7, 1'b0);
        tag = "R3 R6 last slot 1x";
        run_frames(3, 256);

        do_reset(3, 1'b1);
        tag = "R4 R5 2x slot 3";
        run_frames(2, 512);
        tag = "R7 early pulse 2x";
        run_frames(1, 300);
        run_frames(2, 512);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule